// File: doc/BRIEF.md
# Grouped External Interrupt Controller

This block takes sixteen asynchronous interrupt lines from outside the chip and turns them into three interrupt requests for an upstream interrupt controller. Each line is brought into the clock domain by a two-stage synchroniser. It is then tested against a trigger condition. Lines are paired: lines 2k and 2k+1 share one trigger setting. Five conditions are available: low level, high level, falling edge, rising edge and either edge. A detected condition sets a sticky bit in a pending register. A mask register decides which pending bits may reach the outputs.

The three request outputs are the OR of unmasked pending bits over groups of unequal size. The first group holds four lines, the second eight and the third four. The interrupt handler reads the pending and mask registers to find the source, then acknowledges it by writing a one to that pending bit. The register port is a plain synchronous interface with address, write enable, write data and combinational read data.

The trigger decode is an enumerated selection made per pair (`TRIG_LOW`, `TRIG_HIGH`, `TRIG_FALL`, `TRIG_RISE`, `TRIG_BOTH`). It is chosen with a unique case, and each line of the pair then applies the same condition to its own synchronised history. There are no sequential transitions between these modes. The selection changes only when software writes the configuration register, and the new mode applies from the next cycle.

Top module: `xirq_ctrl`

## Requirements
- R1: After reset the configuration register reads 0x00000000, the mask register reads 0x0000FFFF, the pending register reads 0 and all three requests are low.
- R2: The configuration register is at offset 0x900, the mask register at 0x920 and the pending register at 0x924. Bit 3 of every configuration nibble, mask and pending bits 31:16, and every other offset read as zero.
- R3: Trigger code 000 sets the pending bit on each cycle the synchronised line is low, and code 001 sets it on each cycle the line is high.
- R4: Trigger codes 010 and 011 set the pending bit when the synchronised line goes from 1 to 0.
- R5: Trigger codes 100 and 101 set the pending bit on a 0-to-1 change, and codes 110 and 111 set it on a change in either direction.
- R6: Configuration bits 4k+2 to 4k hold the trigger code for pair k, and that code governs both line 2k and line 2k+1.
- R7: A pending bit stays set until it is acknowledged. A register write of 1 to a pending bit clears it, and a written 0 leaves that bit unchanged.
- R8: If a bit is acknowledged in the same cycle that its line detects an event, the bit stays set. In a level mode the acknowledge therefore has no effect while the level remains active.
- R9: A mask bit of 1 keeps its line from any request output, but its pending bit still latches events. A mask bit of 0 lets the line through.
- R10: Request 0 is the OR of unmasked pending bits 3:0, request 1 of bits 11:4 and request 2 of bits 15:12.
- R11: The synchroniser and previous-value stages reset to 1. A change on a line sets its pending bit at the third rising clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 16 | Asynchronous external interrupt lines |
| bus_addr | input | 12 | Register byte offset |
| bus_we | input | 1 | Write strobe, applied at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_grp | output | 3 | Grouped interrupt requests |

## Verification
The bench drives lines 2, 4 and 6, which sit in pairs set to falling, rising and both-edge modes. A design that decoded the trigger field per line, or shifted it by two bits instead of four, would latch the wrong set of pending bits. A level-mode line is acknowledged while it is still active to show that the event wins. A design that let the acknowledge win would drop an interrupt that is still asserted. The synchroniser latency is counted edge by edge, which exposes a stage that is missing or added. Lines at the group borders (3/4 and 11/12) and masked pending bits check that each request covers only its own lines. Random configuration, mask, acknowledge and line activity are then compared each cycle against a cycle model kept by the bench.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

    // Register byte offsets
    localparam logic [11:0] OFS_CFG  = 12'h900;
    localparam logic [11:0] OFS_MASK = 12'h920;
    localparam logic [11:0] OFS_PEND = 12'h924;

    // Width of one pair's trigger code and spacing between codes
    localparam int TRIG_W    = 3;
    localparam int TRIG_STEP = 4;

    typedef enum logic [2:0] {
        TRIG_LOW  = 3'd0,
        TRIG_HIGH = 3'd1,
        TRIG_FALL = 3'd2,
        TRIG_RISE = 3'd3,
        TRIG_BOTH = 3'd4
    } trig_e;

endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
    parameter int NUM_LINES = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] raw,
    output logic [NUM_LINES-1:0] cur,
    output logic [NUM_LINES-1:0] prv
);

    logic [NUM_LINES-1:0] stage1;

    // Two synchroniser stages plus one history stage, all idle-high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '1;
            cur    <= '1;
            prv    <= '1;
        end else begin
            stage1 <= raw;
            cur    <= stage1;
            prv    <= cur;
        end
    end

endmodule

// File: rtl/xirq_detect.sv
module xirq_detect
    import xirq_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int NUM_PAIRS = NUM_LINES / 2
) (
    input  logic [NUM_LINES-1:0]             cur,
    input  logic [NUM_LINES-1:0]             prv,
    input  logic [NUM_PAIRS-1:0][TRIG_W-1:0] cfg,
    output logic [NUM_LINES-1:0]             evt
);

    for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
        trig_e      mode;
        logic [1:0] pair_evt;

        always_comb begin
            unique case (cfg[k])
                3'b000:         mode = TRIG_LOW;
                3'b001:         mode = TRIG_HIGH;
                3'b010, 3'b011: mode = TRIG_FALL;
                3'b100, 3'b101: mode = TRIG_RISE;
                3'b110, 3'b111: mode = TRIG_BOTH;
            endcase
        end

        always_comb begin
            for (int j = 0; j < 2; j++) begin
                unique case (mode)
                    TRIG_LOW:  pair_evt[j] = ~cur[2*k+j];
                    TRIG_HIGH: pair_evt[j] =  cur[2*k+j];
                    TRIG_FALL: pair_evt[j] =  prv[2*k+j] & ~cur[2*k+j];
                    TRIG_RISE: pair_evt[j] = ~prv[2*k+j] &  cur[2*k+j];
                    TRIG_BOTH: pair_evt[j] =  prv[2*k+j] ^  cur[2*k+j];
                    default:   pair_evt[j] = 1'b0;
                endcase
            end
        end

        assign evt[2*k+1:2*k] = pair_evt;
    end

endmodule

// File: rtl/xirq_regs.sv
module xirq_regs
    import xirq_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter int NUM_PAIRS = NUM_LINES / 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [ADDR_W-1:0]                addr,
    input  logic                             we,
    input  logic [DATA_W-1:0]                wdata,
    input  logic [NUM_LINES-1:0]             evt,
    output logic [DATA_W-1:0]                rdata,
    output logic [NUM_PAIRS-1:0][TRIG_W-1:0] cfg_q,
    output logic [NUM_LINES-1:0]             mask_q,
    output logic [NUM_LINES-1:0]             pend_q
);

    localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFS_CFG);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
    localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFS_PEND);

    logic                 hit_cfg, hit_mask, hit_pend;
    logic [NUM_LINES-1:0] ack_vec;
    logic                 unused_wdata;

    assign hit_cfg      = we && (addr == A_CFG);
    assign hit_mask     = we && (addr == A_MASK);
    assign hit_pend     = we && (addr == A_PEND);
    assign ack_vec      = hit_pend ? wdata[NUM_LINES-1:0] : '0;
    assign unused_wdata = ^wdata;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            mask_q <= '1;
            pend_q <= '0;
        end else begin
            if (hit_cfg) begin
                for (int k = 0; k < NUM_PAIRS; k++)
                    cfg_q[k] <= wdata[TRIG_STEP*k +: TRIG_W];
            end
            if (hit_mask)
                mask_q <= wdata[NUM_LINES-1:0];
            // a fresh event outranks a same-cycle acknowledge
            pend_q <= (pend_q & ~ack_vec) | evt;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CFG: begin
                for (int k = 0; k < NUM_PAIRS; k++)
                    rdata[TRIG_STEP*k +: TRIG_W] = cfg_q[k];
            end
            A_MASK:  rdata[NUM_LINES-1:0] = mask_q;
            A_PEND:  rdata[NUM_LINES-1:0] = pend_q;
            default: rdata = '0;
        endcase
    end

    AST_EVT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & $past(evt)) == $past(evt))) else $error("event not latched"); // R7
    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~pend_q & $past(pend_q & ~ack_vec)) == '0)) else $error("pending lost"); // R7
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (|ack_vec) |=> ((pend_q & $past(ack_vec & ~evt)) == '0)) else $error("ack ignored"); // R7
    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ack_vec & evt)) |=> ((pend_q & $past(ack_vec & evt)) == $past(ack_vec & evt)))
        else $error("ack beat event"); // R8

endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl
    import xirq_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter int G0_LAST   = 3,
    parameter int G1_LAST   = 11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] line_in,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic [2:0]           irq_grp
);

    localparam int NUM_PAIRS = NUM_LINES / 2;

    logic [NUM_LINES-1:0]             cur, prv, evt, mask_q, pend_q, live;
    logic [NUM_PAIRS-1:0][TRIG_W-1:0] cfg_q;

    xirq_sync #(.NUM_LINES(NUM_LINES)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw(line_in), .cur(cur), .prv(prv)
    );

    xirq_detect #(.NUM_LINES(NUM_LINES), .NUM_PAIRS(NUM_PAIRS)) u_detect (
        .cur(cur), .prv(prv), .cfg(cfg_q), .evt(evt)
    );

    xirq_regs #(
        .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PAIRS(NUM_PAIRS)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
        .evt(evt), .rdata(bus_rdata), .cfg_q(cfg_q), .mask_q(mask_q), .pend_q(pend_q)
    );

    assign live       = pend_q & ~mask_q;
    assign irq_grp[0] = |live[G0_LAST:0];
    assign irq_grp[1] = |live[G1_LAST:G0_LAST+1];
    assign irq_grp[2] = |live[NUM_LINES-1:G1_LAST+1];

    AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_q) |-> (irq_grp == 3'b000)) else $error("masked line raised request"); // R9
    AST_GROUP_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_grp[1] |-> (|pend_q[G1_LAST:G0_LAST+1])) else $error("group 1 without source"); // R10

endmodule

// File: tb/xirq_ctrl_bench.sv
module xirq_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] b_in = '1;
    logic [11:0] b_addr = '0;
    logic        b_we = 1'b0;
    logic [31:0] b_wdata = '0;
    logic [31:0] rdata;
    logic [2:0]  irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    xirq_ctrl u_xirq_ctrl (
        .clk(clk), .rst_n(rst_n), .line_in(b_in), .bus_addr(b_addr), .bus_we(b_we),
        .bus_wdata(b_wdata), .bus_rdata(rdata), .irq_grp(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // cycle model built from the requirements
    logic [N-1:0] m_s1 = '1, m_s2 = '1, m_prv = '1, m_mask = '1, m_pend = '0;
    logic [31:0]  m_cfg = '0;

    function automatic logic [N-1:0] m_evt();
        logic [N-1:0] e;
        for (int i = 0; i < N; i++) begin
            logic [2:0] f;
            f = m_cfg[4*(i/2) +: 3];
            case (f)
                3'd0:       e[i] = ~m_s2[i];
                3'd1:       e[i] =  m_s2[i];
                3'd2, 3'd3: e[i] =  m_prv[i] & ~m_s2[i];
                3'd4, 3'd5: e[i] = ~m_prv[i] &  m_s2[i];
                default:    e[i] =  m_prv[i] ^  m_s2[i];
            endcase
        end
        return e;
    endfunction

    function automatic logic [31:0] m_read(input logic [11:0] a);
        case (a)
            12'h900: return m_cfg;
            12'h920: return {16'h0, m_mask};
            12'h924: return {16'h0, m_pend};
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [2:0] m_irq();
        logic [N-1:0] l;
        l = m_pend & ~m_mask;
        return {|l[15:12], |l[11:4], |l[3:0]};
    endfunction

    function automatic string tag_of(input logic [11:0] a);
        case (a)
            12'h900: return "R6";
            12'h920: return "R9";
            12'h924: return "R7";
            default: return "R2";
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= '1; m_s2 <= '1; m_prv <= '1;
            m_mask <= '1; m_pend <= '0; m_cfg <= '0;
        end else begin
            logic [N-1:0] ack;
            ack = (b_we && b_addr == 12'h924) ? b_wdata[N-1:0] : '0;
            m_pend <= (m_pend & ~ack) | m_evt();
            m_prv  <= m_s2;
            m_s2   <= m_s1;
            m_s1   <= b_in;
            if (b_we && b_addr == 12'h900) m_cfg <= b_wdata & 32'h77777777;
            if (b_we && b_addr == 12'h920) m_mask <= b_wdata[N-1:0];
        end
    end

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic we, input logic [11:0] a, input logic [31:0] d,
                        input logic [N-1:0] x);
        @(negedge clk);
        b_we = we; b_addr = a; b_wdata = d; b_in = x;
        #1;
        check(rdata, m_read(a), tag_of(a));
        check({29'h0, irq}, {29'h0, m_irq()}, "R10");
    endtask

    task automatic idle(input int n, input logic [N-1:0] x);
        for (int i = 0; i < n; i++) step(1'b0, 12'h924, 32'h0, x);
    endtask

    task automatic peek(input logic [11:0] a, input logic [31:0] exp, input string tag);
        step(1'b0, a, 32'h0, b_in);
        check(rdata, exp, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] x;
        int unsigned seed_val;
        seed_val = $urandom(32'h5EED);

        // R1: state while reset is held
        repeat (2) @(negedge clk);
        b_addr = 12'h900; #1; check(rdata, 32'h0, "R1");
        b_addr = 12'h920; #1; check(rdata, 32'h0000FFFF, "R1");
        b_addr = 12'h924; #1; check(rdata, 32'h0, "R1");
        check({29'h0, irq}, 32'h0, "R1");
        @(negedge clk); rst_n = 1'b1;

        // R2/R6: pair codes high, fall, rise, both; bit 3 written but reads 0
        step(1'b1, 12'h900, 32'h8888ECA9, '1);
        peek(12'h900, 32'h00006421, "R2");
        peek(12'h904, 32'h0, "R2");
        idle(4, '1);
        peek(12'h924, 32'h00000003, "R3");          // high level on lines 0,1
        check({29'h0, irq}, 32'h0, "R9");           // all masked

        // lines 2,4,6 fall: falling pair and both pair fire, rising pair not
        idle(4, 16'hFFAB);
        peek(12'h924, 32'h00000047, "R4");
        idle(4, 16'hFFFF);
        peek(12'h924, 32'h00000057, "R5");

        // acknowledge all: level lines 0,1 still active and stay set
        step(1'b1, 12'h924, 32'h00000057, '1);
        peek(12'h924, 32'h00000003, "R8");
        step(1'b1, 12'h924, 32'h0, '1);
        peek(12'h924, 32'h00000003, "R7");

        // grouping and masking
        step(1'b1, 12'h920, 32'h0000FFFE, '1);
        peek(12'h920, 32'h0000FFFE, "R9");
        check({29'h0, irq}, 32'h1, "R10");
        idle(4, 16'hEFFF);                          // line 12 low, low-level pair
        peek(12'h924, 32'h00001003, "R9");
        check({29'h0, irq}, 32'h1, "R9");
        step(1'b1, 12'h920, 32'h0000EFFE, 16'hFFFF);
        peek(12'h920, 32'h0000EFFE, "R10");
        check({29'h0, irq}, 32'h5, "R10");
        idle(4, 16'hFFFF);
        step(1'b1, 12'h924, 32'h00001000, 16'hFFFF);
        peek(12'h924, 32'h00000003, "R7");
        check({29'h0, irq}, 32'h1, "R10");

        // R11: line 3 (falling pair) latency
        step(1'b0, 12'h924, 32'h0, 16'hFFF7);
        peek(12'h924, 32'h00000003, "R11");
        peek(12'h924, 32'h00000003, "R11");
        peek(12'h924, 32'h0000000B, "R11");

        // random phase
        x = 16'hFFF7;
        for (int n = 0; n < 4000; n++) begin
            int unsigned r;
            r = $urandom % 16;
            x = x ^ 16'($urandom & $urandom & $urandom);
            case (r)
                0:       step(1'b1, 12'h900, $urandom, x);
                1:       step(1'b1, 12'h920, $urandom, x);
                2, 3:    step(1'b1, 12'h924, $urandom, x);
                4:       step(1'b0, 12'h908, 32'h0, x);
                5, 6:    step(1'b0, 12'h900, 32'h0, x);
                7, 8:    step(1'b0, 12'h920, 32'h0, x);
                default: step(1'b0, 12'h924, 32'h0, x);
            endcase
        end

        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule